// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking two levels of tables held in memory. A request carries the linear address and is accepted only while the walker is idle. The top ten bits of the address select a 4-byte entry in a directory page. The directory sits at a frame number supplied on an input port. That entry names the frame of a page table. The next ten bits then select a 4-byte entry in that table, and this entry names the physical frame. The low twelve bits pass straight into the physical result as the offset inside a 4 KB page.

Every table read goes through a request/response read port that can stall. A stalled request holds its address and valid until the memory accepts it. Only one read is ever outstanding. Each level checks the present flag of the entry it fetched. A directory entry that is absent ends the walk at once, with no table read. Either kind of absence gives a one-cycle response marked as a page fault, tagged with vector 14. The faulting linear address is kept on a port until the next fault. When the translation-enable input is low as a request is accepted, the linear address is returned unchanged without touching memory.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, while `resp_valid`, `mem_rd_valid`, `resp_fault` and `fault_lin` are all 0.
- R2: A request accepted while `paging_en` is 0 returns `resp_phys` equal to the request address with `resp_fault` 0. The response comes in the cycle right after acceptance, and no memory read is issued.
- R3: The first read of a walk goes to address `{dir_frame, 12'h000} + 4 * lin[31:22]`.
- R4: If bit 0 (present) of the directory entry is 0, the walk ends with a fault after exactly one memory read.
- R5: The second read goes to address `{dir_entry[31:12], 12'h000} + 4 * lin[21:12]`. Bits 11:1 of the directory entry have no effect on it.
- R6: If bit 0 of the table entry is 0, the walk ends with a fault after exactly two memory reads.
- R7: If both entries have bit 0 set, `resp_phys` is `{table_entry[31:12], lin[11:0]}` with `resp_fault` 0, after exactly two reads.
- R8: A fault response has `resp_fault` 1 and `fault_vec` 14, and it loads `fault_lin` with the linear address of that walk. `fault_lin` keeps its value until the next fault. `fault_vec` is 0 on a response without a fault.
- R9: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, `mem_rd_valid` stays 1 and `mem_rd_addr` stays the same in the next cycle. `mem_rd_valid` is 0 while a read response is awaited.
- R10: `req_ready` is 0 from the cycle after a translating request is accepted until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable, sampled when a request is accepted |
| dir_frame | input | 20 | Frame number of the directory page |
| req_valid | input | 1 | Translation request |
| req_lin | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Result is a page fault |
| resp_phys | output | 32 | Physical address (0 on a fault) |
| fault_lin | output | 32 | Linear address of the latest fault |
| fault_vec | output | 8 | Exception vector, 14 on a fault |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
A wrong state or a wrong latched table frame shows up at the memory port within one request. It appears as a read address off the two formulas or as the wrong number of reads before the response. A present bit decoded from the wrong level changes the fault flag or the physical frame of that same response. A corrupted fault-address register is seen at the next response of either kind, because the faulting address must persist across successful walks. A lost stall shows in the cycle after a refused read, when the address changes or the valid drops.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [2:0] {
        WK_IDLE   = 3'd0,
        WK_DIR_RD = 3'd1,
        WK_DIR_WT = 3'd2,
        WK_TBL_RD = 3'd3,
        WK_TBL_WT = 3'd4
    } walk_state_e;

    localparam int WK_LEVELS = 2;

endpackage

// File: rtl/walk_entry_addr.sv
// Byte address of one 4-byte entry: base frame plus scaled index.
module walk_entry_addr #(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic [AW-OFF_W-1:0] base_frame,
    input  logic [IDX_W-1:0]    index,
    output logic [AW-1:0]       addr
);
    localparam int ENT_SH = OFF_W - IDX_W;

    always_comb begin
        addr = {base_frame, {OFF_W{1'b0}}} + (AW'(index) << ENT_SH);
    end
endmodule

// File: rtl/walk_entry_dec.sv
// Splits a fetched entry into its present flag and frame number.
module walk_entry_dec #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic [AW-1:0]       entry,
    output logic                present,
    output logic [AW-OFF_W-1:0] frame
);
    logic unused_attr;

    assign present     = entry[0];
    assign frame       = entry[AW-1:OFF_W];
    assign unused_attr = ^entry[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import walk_pkg::*;
#(
    parameter int AW        = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int VEC_W     = 8,
    parameter int PF_VECTOR = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                paging_en,
    input  logic [AW-OFF_W-1:0] dir_frame,
    input  logic                req_valid,
    input  logic [AW-1:0]       req_lin,
    output logic                req_ready,
    output logic                resp_valid,
    output logic                resp_fault,
    output logic [AW-1:0]       resp_phys,
    output logic [AW-1:0]       fault_lin,
    output logic [VEC_W-1:0]    fault_vec,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [AW-1:0]       mem_rd_addr,
    input  logic                mem_rsp_valid,
    input  logic [AW-1:0]       mem_rsp_data
);
    localparam int FRAME_W  = AW - OFF_W;
    localparam int DIR_LSB  = OFF_W + IDX_W;

    typedef struct packed {
        walk_state_e        st;
        logic [AW-1:0]      lin;
        logic [FRAME_W-1:0] tbl;
        logic               rv;
        logic               flt;
        logic [AW-1:0]      phys;
        logic [AW-1:0]      flin;
        logic [VEC_W-1:0]   vec;
    } walk_regs_t;

    walk_regs_t q, d;

    // Per-level entry address generators
    logic [FRAME_W-1:0] lvl_base [WK_LEVELS];
    logic [IDX_W-1:0]   lvl_idx  [WK_LEVELS];
    logic [AW-1:0]      lvl_addr [WK_LEVELS];

    assign lvl_base[0] = dir_frame;
    assign lvl_idx[0]  = q.lin[AW-1:DIR_LSB];
    assign lvl_base[1] = q.tbl;
    assign lvl_idx[1]  = q.lin[DIR_LSB-1:OFF_W];

    for (genvar g = 0; g < WK_LEVELS; g++) begin : g_lvl
        walk_entry_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
            .base_frame (lvl_base[g]),
            .index      (lvl_idx[g]),
            .addr       (lvl_addr[g])
        );
    end

    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;

    walk_entry_dec #(.AW(AW), .OFF_W(OFF_W)) u_dec (
        .entry   (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    // Next-state computation
    always_comb begin
        d      = q;
        d.rv   = 1'b0;
        d.flt  = 1'b0;
        d.vec  = '0;
        unique case (q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    if (paging_en) begin
                        d.st  = WK_DIR_RD;
                        d.lin = req_lin;
                    end else begin
                        d.rv   = 1'b1;
                        d.phys = req_lin;
                    end
                end
            end
            WK_DIR_RD: begin
                if (mem_rd_ready) d.st = WK_DIR_WT;
            end
            WK_DIR_WT: begin
                if (mem_rsp_valid) begin
                    if (ent_present) begin
                        d.tbl = ent_frame;
                        d.st  = WK_TBL_RD;
                    end else begin
                        d.st   = WK_IDLE;
                        d.rv   = 1'b1;
                        d.flt  = 1'b1;
                        d.phys = '0;
                        d.flin = q.lin;
                        d.vec  = VEC_W'(PF_VECTOR);
                    end
                end
            end
            WK_TBL_RD: begin
                if (mem_rd_ready) d.st = WK_TBL_WT;
            end
            WK_TBL_WT: begin
                if (mem_rsp_valid) begin
                    d.st = WK_IDLE;
                    d.rv = 1'b1;
                    if (ent_present) begin
                        d.phys = {ent_frame, q.lin[OFF_W-1:0]};
                    end else begin
                        d.flt  = 1'b1;
                        d.phys = '0;
                        d.flin = q.lin;
                        d.vec  = VEC_W'(PF_VECTOR);
                    end
                end
            end
            default: d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: WK_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == WK_IDLE);
    assign mem_rd_valid = (q.st == WK_DIR_RD) || (q.st == WK_TBL_RD);
    assign mem_rd_addr  = (q.st == WK_TBL_RD) ? lvl_addr[1] : lvl_addr[0];
    assign resp_valid   = q.rv;
    assign resp_fault   = q.flt;
    assign resp_phys    = q.phys;
    assign fault_lin    = q.flin;
    assign fault_vec    = q.vec;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int AW        = 32,
    parameter int VEC_W     = 8,
    parameter int PF_VECTOR = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             paging_en,
    input logic             req_valid,
    input logic [AW-1:0]    req_lin,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_fault,
    input logic [AW-1:0]    resp_phys,
    input logic [AW-1:0]    fault_lin,
    input logic [VEC_W-1:0] fault_vec,
    input logic             mem_rd_valid,
    input logic             mem_rd_ready,
    input logic [AW-1:0]    mem_rd_addr
);
    // R9: a refused read request is held with the same address
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R9: an accepted read is followed by a wait with no request
    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

    // R10: no request acceptance while a table read is pending
    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    // R2: bypass returns the address unchanged in the next cycle
    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
            (resp_valid && !resp_fault && resp_phys == $past(req_lin)));

    // R8: fault flag only with a response, and it carries the vector
    assert_fault_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_valid && fault_vec == VEC_W'(PF_VECTOR)));

    // R8: faulting address changes only when a fault is reported
    assert_flin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_fault |=> (resp_fault || $stable(fault_lin)));

    // R8: no vector without a fault
    assert_no_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_fault |-> (fault_vec == '0));
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .VEC_W(VEC_W), .PF_VECTOR(PF_VECTOR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .paging_en    (paging_en),
    .req_valid    (req_valid),
    .req_lin      (req_lin),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_fault   (resp_fault),
    .resp_phys    (resp_phys),
    .fault_lin    (fault_lin),
    .fault_vec    (fault_vec),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [19:0] dir_frame = 20'h00010;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_fault;
    logic [31:0] resp_phys;
    logic [31:0] fault_lin;
    logic [7:0]  fault_vec;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_frame(dir_frame),
        .req_valid(req_valid), .req_lin(req_lin), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_phys(resp_phys),
        .fault_lin(fault_lin), .fault_vec(fault_vec),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [31:0] lin;
        logic [31:0] phys;
        logic        fault;
        int          reads;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] addr_q[$];
    logic [31:0] mem [logic [31:0]];

    int          checks = 0;
    int          fails = 0;
    int          reads_seen = 0;
    logic [31:0] last_flin = '0;
    bit          slow = 1'b0;
    int          lat = 0;
    bit          pend = 1'b0;
    int          cd = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pend_addr);
                    pend = 1'b0;
                end else begin
                    cd--;
                end
            end
            mem_rd_ready = slow ? ~mem_rd_ready : 1'b1;
            if (mem_rd_valid && mem_rd_ready) begin
                reads_seen++;
                pend = 1'b1;
                pend_addr = mem_rd_addr;
                cd = lat;
                if (addr_q.size() == 0) begin
                    chk(1'b0, "R3/R5", "unexpected read", mem_rd_addr, 32'h0);
                end else begin
                    logic [31:0] ea;
                    ea = addr_q.pop_front();
                    chk(mem_rd_addr == ea, "R3/R5", "read address", mem_rd_addr, ea);
                end
            end
            if (resp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", "unexpected response", resp_phys, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(resp_fault == e.fault, "R4/R6/R7", "fault flag",
                        32'(resp_fault), 32'(e.fault));
                    chk(reads_seen == e.reads, "R2/R4/R6/R7", "read count",
                        32'(reads_seen), 32'(e.reads));
                    if (e.fault) begin
                        last_flin = e.lin;
                        chk(fault_vec == 8'd14, "R8", "vector", 32'(fault_vec), 32'd14);
                    end else begin
                        chk(resp_phys == e.phys, "R2/R7", "physical address", resp_phys, e.phys);
                        chk(fault_vec == 8'd0, "R8", "vector clear", 32'(fault_vec), 32'd0);
                    end
                    chk(fault_lin == last_flin, "R8", "fault address", fault_lin, last_flin);
                end
                reads_seen = 0;
            end
        end
    end

    task automatic translate(input logic [31:0] lin, input logic pg);
        exp_t        e;
        logic [31:0] pa, pde, ta, pte;
        e.lin = lin; e.phys = lin; e.fault = 1'b0; e.reads = 0;
        if (pg) begin
            pa = {dir_frame, 12'h000} + {20'h0, lin[31:22], 2'b00};
            pde = rd(pa);
            addr_q.push_back(pa);
            e.reads = 1;
            if (!pde[0]) begin
                e.fault = 1'b1;
            end else begin
                ta = {pde[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00};
                pte = rd(ta);
                addr_q.push_back(ta);
                e.reads = 2;
                if (!pte[0]) e.fault = 1'b1;
                else e.phys = {pte[31:12], lin[11:0]};
            end
        end
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_lin = lin; paging_en = pg;
        @(negedge clk);
        req_valid = 1'b0;
        if (!pg) chk(resp_valid == 1'b1, "R2", "bypass latency", 32'(resp_valid), 32'd1);
        else     chk(req_ready == 1'b0, "R10", "busy during walk", 32'(req_ready), 32'd0);
        while (sb.size() != 0) @(negedge clk);
        chk(addr_q.size() == 0, "R4/R6", "reads left over", 32'(addr_q.size()), 32'd0);
        addr_q.delete();
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        mem[32'h0001_0004] = 32'h0002_0067;   // dir idx 1, attribute bits set
        mem[32'h0002_000C] = 32'h1234_5001;
        mem[32'h0002_0014] = 32'h5555_5000;   // table entry absent
        mem[32'h0002_0FFC] = 32'hFFFF_F003;
        mem[32'h0001_0008] = 32'h0003_0FFE;   // dir entry absent
        mem[32'h0001_0FFC] = 32'h0004_0001;
        mem[32'h0004_0000] = 32'h00AB_C001;
        mem[32'h0005_0004] = 32'h0006_0001;
        mem[32'h0006_000C] = 32'h7777_7001;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R1", "resp_valid", 32'(resp_valid), 32'd0);
        chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid", 32'(mem_rd_valid), 32'd0);
        chk(fault_lin == 32'h0 && resp_fault == 1'b0, "R1", "fault state", fault_lin, 32'h0);
        rst_n = 1'b1;

        translate(32'h0040_3ABC, 1'b1);   // R7, R5 low entry bits ignored
        translate(32'hDEAD_BEEF, 1'b0);   // R2
        translate(32'h0040_3ABC, 1'b0);   // R2 mapped address untouched
        translate(32'h0080_0010, 1'b1);   // R4 single read
        translate(32'h007F_FFFF, 1'b1);   // R7 top table index
        translate(32'h0040_5123, 1'b1);   // R6 absent table entry
        translate(32'hFFC0_0777, 1'b1);   // R3 top directory index
        translate(32'h0000_0100, 1'b1);   // R4 unmapped directory slot
        translate(32'h0040_3ABC, 1'b1);   // R8 fault address held
        dir_frame = 20'h00050;
        translate(32'h0040_3ABC, 1'b1);   // R3 moved directory
        dir_frame = 20'h00010;
        slow = 1'b1; lat = 3;
        translate(32'h0040_3ABC, 1'b1);   // R9 stalled reads
        translate(32'h0080_0010, 1'b1);
        translate(32'h0040_5123, 1'b1);
        translate(32'h1234_5678, 1'b0);
        slow = 1'b0; lat = 0;
        translate(32'hFFC0_0000, 1'b1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule